// File: doc/BRIEF.md
# Reset-Gated Video Register Port

This block is the processor-facing side of a video controller's eight-entry register window. The processor presents a 3-bit register index, an active-low chip select, a read/write level and a one-cycle access strobe. The chip select spans a large address range, so the eight entries repeat across it. The block captures byte writes into a control register, a mask register and a two-write scroll port. The scroll port shares one first/second toggle, and it fills a 15-bit temporary address latch and a 3-bit fine horizontal offset. A strobed read of the data entry loads a read buffer from the memory data input.

After reset, the block stays in a hold phase for one full frame. In that phase the control and mask registers, the scroll latch, the fine offset, the toggle and the read buffer are kept at zero, and every access is discarded. The hold ends on the first frame-end pulse after reset is released. Two named states carry this behaviour. `ST_HOLD` is entered on reset. `ST_RUN` is entered through the transition *frame_end_release* (a `frame_done` pulse while in `ST_HOLD`). `ST_RUN` has a single transition, *stay_run*, back to itself, so only reset leaves it. A frame parity flag flips on every frame-end pulse and is cleared by reset.

Top module: `vpu_reg_port`

## Requirements
- R1: While `rst_n` is low and right after it is released, `hold` is 1, `odd_frame` is 0 and `ctrl_q`, `mask_q`, `t_addr`, `fine_x`, `w_toggle` and `rdbuf_q` are all zero.
- R2: While `hold` is 1, no access changes any register. Writes to indices 0, 1 and 5 and reads of index 7 all leave every register output at zero.
- R3: A `frame_done` pulse while `hold` is 1 makes `hold` 0 from the next clock edge. An access made in that same cycle is still discarded. `hold` stays 0 until the next reset.
- R4: A write happens only in a cycle where `strobe`=1, `sel_n`=0 and `rw`=0. A write to index 2, 3, 4, 6 or 7, or any cycle with `sel_n`=1, changes no register.
- R5: A write to index 0 stores the byte in `ctrl_q` and copies data bits [1:0] into `t_addr[11:10]`.
- R6: A write to index 1 stores the byte in `mask_q`.
- R7: A write to index 5 with `w_toggle`=0 sets `t_addr[4:0]` to data[7:3] and `fine_x` to data[2:0], then sets `w_toggle` to 1.
- R8: A write to index 5 with `w_toggle`=1 sets `t_addr[14:12]` to data[2:0] and `t_addr[9:5]` to data[7:3], then clears `w_toggle`. `fine_x` does not change.
- R9: A strobed read (`rw`=1, `sel_n`=0) of index 7 loads `rdbuf_q` from `vram_rdata`. A read of any index changes no other register.
- R10: `ext_drive` equals bit 6 of `ctrl_q`. A value of 1 means the block drives the external palette-index pins; 0 means it reads them.
- R11: `odd_frame` flips on every clock edge at which `frame_done` is 1, in both states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low register window select |
| rw | input | 1 | 1 = read, 0 = write |
| strobe | input | 1 | One-cycle access strobe |
| addr | input | 3 | Register index 0..7 |
| wdata | input | 8 | Write data |
| vram_rdata | input | 8 | Memory data captured on a read of index 7 |
| frame_done | input | 1 | One-cycle frame-end pulse |
| hold | output | 1 | 1 while in the post-reset hold phase |
| odd_frame | output | 1 | Frame parity flag |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| t_addr | output | 15 | Temporary address latch |
| fine_x | output | 3 | Fine horizontal offset |
| w_toggle | output | 1 | Scroll first/second write toggle |
| rdbuf_q | output | 8 | Read buffer |
| ext_drive | output | 1 | Palette-index pin direction (1 = drive) |

## Verification
Every register result is due at the rising edge that samples the strobe, so it is visible one edge after the access. `hold` falls one edge after the `frame_done` pulse, and `ext_drive` follows `ctrl_q` with no extra delay. The bench applies inputs on the falling edge and samples every output 1 ns after the next rising edge. Its reference model advances once per edge, using the hold state from before that edge. A write made in the same cycle as the releasing pulse is therefore expected to be dropped.

// File: rtl/vpu_pkg.sv
package vpu_pkg;
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } hold_state_t;

    localparam int unsigned IDX_CTRL   = 0;
    localparam int unsigned IDX_MASK   = 1;
    localparam int unsigned IDX_SCROLL = 5;
    localparam int unsigned IDX_DATA   = 7;
endpackage

// File: rtl/vpu_hold_fsm.sv
module vpu_hold_fsm
    import vpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    output logic hold,
    output logic odd_frame
);
    hold_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (frame_done) state_d = ST_RUN;   // frame_end_release
            ST_RUN:  state_d = ST_RUN;                   // stay_run
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          odd_frame <= 1'b0;
        else if (frame_done) odd_frame <= ~odd_frame;
    end

    assign hold = (state_q == ST_HOLD);

    // R3
    release_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && frame_done) |=> !hold);
    // R3
    run_is_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> !hold);
    // R11
    parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (odd_frame != $past(odd_frame)));
endmodule

// File: rtl/vpu_scroll_regs.sv
module vpu_scroll_regs #(
    parameter int COARSE_W = 5,
    parameter int FINE_W   = 3,
    localparam int DATA_W  = COARSE_W + FINE_W,
    localparam int T_W     = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_scroll,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [T_W-1:0]    t_addr,
    output logic [FINE_W-1:0] fine_x,
    output logic              w_toggle
);
    localparam int CY_LO = COARSE_W;
    localparam int NT_LO = 2 * COARSE_W;
    localparam int FY_LO = 2 * COARSE_W + 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_addr   <= '0;
            fine_x   <= '0;
            w_toggle <= 1'b0;
        end else if (hold) begin
            t_addr   <= '0;
            fine_x   <= '0;
            w_toggle <= 1'b0;
        end else begin
            if (wr_ctrl)
                t_addr[NT_LO+1:NT_LO] <= wdata[1:0];
            if (wr_scroll) begin
                if (!w_toggle) begin
                    t_addr[COARSE_W-1:0] <= wdata[DATA_W-1:FINE_W];
                    fine_x               <= wdata[FINE_W-1:0];
                    w_toggle             <= 1'b1;
                end else begin
                    t_addr[T_W-1:FY_LO]       <= wdata[FINE_W-1:0];
                    t_addr[NT_LO-1:CY_LO]     <= wdata[DATA_W-1:FINE_W];
                    w_toggle                  <= 1'b0;
                end
            end
        end
    end

    // R7
    first_write_sets_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr_scroll && !w_toggle) |=> w_toggle);
    // R8
    second_write_clears_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr_scroll && w_toggle) |=> (!w_toggle && $stable(fine_x)));
endmodule

// File: rtl/vpu_reg_port.sv
module vpu_reg_port
    import vpu_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int COARSE_W = 5,
    parameter int FINE_W   = 3,
    localparam int DATA_W  = COARSE_W + FINE_W,
    localparam int T_W     = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rw,
    input  logic              strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic              frame_done,
    output logic              hold,
    output logic              odd_frame,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [T_W-1:0]    t_addr,
    output logic [FINE_W-1:0] fine_x,
    output logic              w_toggle,
    output logic [DATA_W-1:0] rdbuf_q,
    output logic              ext_drive
);
    logic access, wr_en, rd_en;
    logic wr_ctrl, wr_mask, wr_scroll, rd_data;

    assign access    = strobe && !sel_n;
    assign wr_en     = access && !rw;
    assign rd_en     = access && rw;
    assign wr_ctrl   = wr_en && (addr == ADDR_W'(IDX_CTRL));
    assign wr_mask   = wr_en && (addr == ADDR_W'(IDX_MASK));
    assign wr_scroll = wr_en && (addr == ADDR_W'(IDX_SCROLL));
    assign rd_data   = rd_en && (addr == ADDR_W'(IDX_DATA));

    vpu_hold_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .hold       (hold),
        .odd_frame  (odd_frame)
    );

    vpu_scroll_regs #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_scroll (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .wr_scroll (wr_scroll),
        .wr_ctrl   (wr_ctrl),
        .wdata     (wdata),
        .t_addr    (t_addr),
        .fine_x    (fine_x),
        .w_toggle  (w_toggle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            rdbuf_q <= '0;
        end else if (hold) begin
            ctrl_q  <= '0;
            mask_q  <= '0;
            rdbuf_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q  <= wdata;
            if (wr_mask) mask_q  <= wdata;
            if (rd_data) rdbuf_q <= vram_rdata;
        end
    end

    assign ext_drive = ctrl_q[6];

    // R2
    hold_keeps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (ctrl_q == '0 && mask_q == '0 && rdbuf_q == '0 &&
                  t_addr == '0 && fine_x == '0 && !w_toggle));
    // R4
    ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !(strobe && !sel_n && !rw && addr == ADDR_W'(IDX_CTRL))) |=> $stable(ctrl_q));
    // R6
    mask_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !(strobe && !sel_n && !rw && addr == ADDR_W'(IDX_MASK))) |=> $stable(mask_q));
    // R9
    rdbuf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && strobe && !sel_n && rw && addr == ADDR_W'(IDX_DATA)) |=> (rdbuf_q == $past(vram_rdata)));
endmodule

// File: tb/vpu_reg_port_tb.sv
module vpu_reg_port_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, rw = 1'b1, strobe = 1'b0, frame_done = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, vram_rdata = '0;
    logic hold, odd_frame, w_toggle, ext_drive;
    logic [7:0] ctrl_q, mask_q, rdbuf_q;
    logic [14:0] t_addr;
    logic [2:0] fine_x;

    int total = 0, bad = 0;
    logic m_hold, m_odd, m_tog;
    logic [7:0] m_ctrl, m_mask, m_rb;
    logic [14:0] m_t;
    logic [2:0] m_fx;

    always #10 clk = ~clk;

    vpu_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw(rw), .strobe(strobe),
        .addr(addr), .wdata(wdata), .vram_rdata(vram_rdata), .frame_done(frame_done),
        .hold(hold), .odd_frame(odd_frame), .ctrl_q(ctrl_q), .mask_q(mask_q),
        .t_addr(t_addr), .fine_x(fine_x), .w_toggle(w_toggle), .rdbuf_q(rdbuf_q),
        .ext_drive(ext_drive)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "hold", hold, m_hold);
        chk(tag, "odd_frame", odd_frame, m_odd);
        chk(tag, "ctrl_q", ctrl_q, m_ctrl);
        chk(tag, "mask_q", mask_q, m_mask);
        chk(tag, "t_addr", t_addr, m_t);
        chk(tag, "fine_x", fine_x, m_fx);
        chk(tag, "w_toggle", w_toggle, m_tog);
        chk(tag, "rdbuf_q", rdbuf_q, m_rb);
        chk(tag, "ext_drive", ext_drive, m_ctrl[6]);   // R10
    endtask

    function automatic void model_reset();
        m_hold = 1'b1; m_odd = 1'b0; m_tog = 1'b0;
        m_ctrl = '0; m_mask = '0; m_rb = '0; m_t = '0; m_fx = '0;
    endfunction

    function automatic void model_step(input logic s, input logic sn, input logic r,
                                       input logic [2:0] a, input logic [7:0] d,
                                       input logic [7:0] vr, input logic fd);
        if (!m_hold) begin
            if (s && !sn && !r) begin
                case (a)
                    3'd0: begin m_ctrl = d; m_t[11:10] = d[1:0]; end
                    3'd1: m_mask = d;
                    3'd5: begin
                        if (!m_tog) begin
                            m_t[4:0] = d[7:3]; m_fx = d[2:0]; m_tog = 1'b1;
                        end else begin
                            m_t[14:12] = d[2:0]; m_t[9:5] = d[7:3]; m_tog = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (s && !sn && r && a == 3'd7) m_rb = vr;
        end
        if (fd) m_odd = ~m_odd;
        if (m_hold && fd) m_hold = 1'b0;
    endfunction

    task automatic step(input logic s, input logic sn, input logic r, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] vr, input logic fd,
                        input string tag);
        @(negedge clk);
        strobe = s; sel_n = sn; rw = r; addr = a; wdata = d; vram_rdata = vr; frame_done = fd;
        @(posedge clk);
        model_step(s, sn, r, a, d, vr, fd);
        #1;
        check_all(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        step(1'b1, 1'b0, 1'b0, a, d, 8'h00, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe = 1'b0; frame_done = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_all("R1");
    endtask

    initial begin
        #3000000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R2: accesses during hold are dropped
        wr(3'd0, 8'hFF, "R2");
        wr(3'd1, 8'hA5, "R2");
        wr(3'd5, 8'h7B, "R2");
        step(1'b1, 1'b0, 1'b1, 3'd7, 8'h00, 8'h3C, 1'b0, "R2");
        // R3: write in the releasing cycle is dropped
        step(1'b1, 1'b0, 1'b0, 3'd0, 8'h55, 8'h00, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 1'b0, "R3");
        // R5 and R10
        wr(3'd0, 8'h43, "R5");
        wr(3'd0, 8'h02, "R10");
        // R6
        wr(3'd1, 8'h9E, "R6");
        // R7, R8
        wr(3'd5, 8'hD6, "R7");
        wr(3'd5, 8'h5B, "R8");
        wr(3'd5, 8'h29, "R7");
        // R4: other indices, deselected, read level
        wr(3'd2, 8'hFF, "R4");
        wr(3'd3, 8'hFF, "R4");
        wr(3'd7, 8'hFF, "R4");
        step(1'b1, 1'b1, 1'b0, 3'd1, 8'h11, 8'h00, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, 3'd1, 8'h22, 8'h00, 1'b0, "R4");
        // R9
        step(1'b1, 1'b0, 1'b1, 3'd7, 8'h00, 8'hC3, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b1, 3'd0, 8'h00, 8'h18, 1'b0, "R9");
        // R11: parity in run state; R3 hold stays low
        step(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 1'b1, "R11");
        step(1'b0, 1'b1, 1'b1, 3'd0, 8'h00, 8'h00, 1'b1, "R11");
        // re-reset returns to hold
        do_reset();
        wr(3'd1, 8'h77, "R2");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic s, sn, r, fd;
            logic [2:0] a;
            logic [7:0] d, vr;
            s  = ($urandom % 4) != 0;
            sn = ($urandom % 6) == 0;
            r  = ($urandom % 4) == 0;
            a  = 3'($urandom);
            d  = 8'($urandom);
            vr = 8'($urandom);
            fd = ($urandom % 60) == 0;
            if (i % 1000 == 999) do_reset();
            else step(s, sn, r, a, d, vr, fd, "RND");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule